// File: doc/BRIEF.md
# Single-Cycle Y86 Processor Core

This block is a non-pipelined processor for the small 32-bit Y86 instruction set. It completes one whole instruction on every rising clock edge. In each cycle it takes a window of six bytes starting at the program counter and splits it into the opcode, the function code, the two register fields and the constant word. It then reads up to two registers, runs the ALU, makes at most one 32-bit data memory access, and computes the next program counter. The PC, the condition flags, the eight-entry register file and memory all take their new values together at the edge.

Code and data share one little-endian byte array inside the block. A byte-wide load port fills this array while the core is held in reset. After reset is released, the core runs until it meets a halt or an opcode it does not know. It then raises a stopped flag, marks an unknown opcode with a fault flag, and changes no state from then on. Two read-only observation ports let the surrounding logic look at any register and any memory word once a program has stopped.

Top module: `seqcore_top`

## Requirements
- R1: The opcode is bits 7:4 of the first instruction byte and the function code is bits 3:0. Where a register byte exists, it follows directly, with the first operand register (rA) in bits 7:4 and the second (rB) in bits 3:0. The 32-bit constant is stored least significant byte first. Register IDs are 0 %eax, 1 %ecx, 2 %edx, 3 %ebx, 4 %esp, 5 %ebp, 6 %esi and 7 %edi.
- R2: The fall-through PC is the PC plus the instruction length. The length is 1 for nop (0x0), halt (0x1) and ret (0x9). It is 2 for rrmovl (0x2), OPl (0x6), pushl (0xA) and popl (0xB). It is 5 for jXX (0x7) and call (0x8), and 6 for irmovl (0x3), rmmovl (0x4) and mrmovl (0x5).
- R3: OPl writes rB op rA into rB. Function 0 adds, 1 subtracts (rB minus rA), 2 ANDs and 3 XORs.
- R4: Only OPl loads the flags, which appear on `flags` as {ZF, SF, OF}. ZF is set for a zero result and SF copies the sign bit. OF is set on signed overflow of add or subtract and is cleared by AND and XOR.
- R5: jXX goes to the constant when its condition holds and falls through otherwise. The conditions by function code are: 0 always, 1 (SF^OF)|ZF, 2 SF^OF, 3 ZF, 4 !ZF, 5 !(SF^OF), 6 !(SF^OF)&!ZF.
- R6: rrmovl copies rA to rB and irmovl writes the constant to rB. rmmovl stores rA to the word at rB+constant, and mrmovl loads rA from the word at that address.
- R7: pushl subtracts 4 from %esp and stores rA at the new %esp. popl loads rA from the old %esp and adds 4 to %esp. When popl names %esp as rA, the loaded value wins over the incremented pointer.
- R8: call stores its fall-through address at %esp-4, moves %esp down by 4 and jumps to the constant. ret jumps to the word at %esp and moves %esp up by 4.
- R9: A halt raises `stopped` with `fault` low. The PC stays at the halt address and no register, flag or memory state changes after that.
- R10: An opcode of 0xC to 0xF raises `stopped` and `fault`. The instruction has no effect and the PC stays at its address.
- R11: While reset is active, the PC is 0, the flags are {ZF,SF,OF}=100, all registers are 0, and `stopped` and `fault` are low.
- R12: A load-port write stores `ld_data` at byte `ld_addr`. It can be read back through the memory observation port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load-port byte write enable |
| ld_addr | input | AW | Load-port byte address |
| ld_data | input | 8 | Load-port byte value |
| obs_reg_sel | input | 4 | Register ID to observe |
| obs_reg_val | output | 32 | Value of the observed register (0 for IDs above 7) |
| obs_mem_addr | input | AW | Byte address of the observed memory word |
| obs_mem_word | output | 32 | Little-endian word starting at obs_mem_addr |
| pc | output | 32 | Current program counter |
| flags | output | 3 | Condition flags {ZF, SF, OF} |
| stopped | output | 1 | Core has stopped on halt or a bad opcode |
| fault | output | 1 | The stop was caused by a bad opcode |

## Verification
The bench builds the core with its default 1024-byte memory and a reset PC of 0. With these values, code at address 0 and a stack just below 0x100 fit well inside the array, so the tests never touch address wrap-around. They do reach every opcode, all seven branch conditions against equal, lower and higher operands, and signed overflow in both directions. They also cover popl into %esp, an unaligned word read that shows the byte order, and the frozen state after both kinds of stop.

// File: rtl/seqcore_pkg.sv
package seqcore_pkg;

    localparam int XLEN      = 32;
    localparam int FETCH_LEN = 6;
    localparam int NIB       = 4;

    localparam logic [NIB-1:0] OP_NOP   = 4'h0;
    localparam logic [NIB-1:0] OP_HALT  = 4'h1;
    localparam logic [NIB-1:0] OP_RRMOV = 4'h2;
    localparam logic [NIB-1:0] OP_IRMOV = 4'h3;
    localparam logic [NIB-1:0] OP_RMMOV = 4'h4;
    localparam logic [NIB-1:0] OP_MRMOV = 4'h5;
    localparam logic [NIB-1:0] OP_ALU   = 4'h6;
    localparam logic [NIB-1:0] OP_JUMP  = 4'h7;
    localparam logic [NIB-1:0] OP_CALL  = 4'h8;
    localparam logic [NIB-1:0] OP_RET   = 4'h9;
    localparam logic [NIB-1:0] OP_PUSH  = 4'hA;
    localparam logic [NIB-1:0] OP_POP   = 4'hB;

    localparam logic [NIB-1:0] FN_ADD = 4'h0;
    localparam logic [NIB-1:0] FN_SUB = 4'h1;
    localparam logic [NIB-1:0] FN_AND = 4'h2;
    localparam logic [NIB-1:0] FN_XOR = 4'h3;

    localparam logic [NIB-1:0] REG_SP   = 4'h4;
    localparam logic [NIB-1:0] REG_NONE = 4'h8;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    typedef struct packed {
        logic [NIB-1:0]  icode;
        logic [NIB-1:0]  ifun;
        logic [NIB-1:0]  ra;
        logic [NIB-1:0]  rb;
        logic [XLEN-1:0] valc;
        logic [XLEN-1:0] valp;
        logic            valid;
    } fetch_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        flags_t          cc;
        logic            stopped;
        logic            fault;
    } core_state_t;

    function automatic logic branch_taken(input logic [NIB-1:0] fn, input flags_t f);
        logic lt;
        lt = f.sf ^ f.of;
        case (fn)
            4'h0:    return 1'b1;
            4'h1:    return lt | f.zf;
            4'h2:    return lt;
            4'h3:    return f.zf;
            4'h4:    return ~f.zf;
            4'h5:    return ~lt;
            4'h6:    return ~lt & ~f.zf;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seqcore_fetch.sv
module seqcore_fetch
    import seqcore_pkg::*;
(
    input  logic [XLEN-1:0]        pc_i,
    input  logic [FETCH_LEN*8-1:0] bytes_i,
    output fetch_t                 fet_o
);

    logic need_regs;
    logic need_const;

    always_comb begin
        fet_o.icode = bytes_i[7:4];
        fet_o.ifun  = bytes_i[3:0];
        fet_o.valid = (bytes_i[7:4] <= OP_POP);

        need_regs  = fet_o.icode inside {OP_RRMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
                                         OP_ALU, OP_PUSH, OP_POP};
        need_const = fet_o.icode inside {OP_IRMOV, OP_RMMOV, OP_MRMOV, OP_JUMP, OP_CALL};

        fet_o.ra   = need_regs ? bytes_i[15:12] : REG_NONE;
        fet_o.rb   = need_regs ? bytes_i[11:8]  : REG_NONE;
        fet_o.valc = need_regs ? bytes_i[47:16] : bytes_i[39:8];
        fet_o.valp = pc_i + XLEN'(1)
                   + (need_regs  ? XLEN'(1) : XLEN'(0))
                   + (need_const ? XLEN'(4) : XLEN'(0));
    end

endmodule

// File: rtl/seqcore_alu.sv
module seqcore_alu
    import seqcore_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [NIB-1:0]  fn_i,
    output logic [XLEN-1:0] res_o,
    output flags_t          flags_o
);

    localparam int MSB = XLEN - 1;

    always_comb begin
        flags_o.of = 1'b0;
        case (fn_i)
            FN_SUB: begin
                res_o      = b_i - a_i;
                flags_o.of = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
            end
            FN_AND: res_o = b_i & a_i;
            FN_XOR: res_o = b_i ^ a_i;
            default: begin
                res_o      = b_i + a_i;
                flags_o.of = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
            end
        endcase
        flags_o.zf = (res_o == '0);
        flags_o.sf = res_o[MSB];
    end

endmodule

// File: rtl/seqcore_regfile.sv
module seqcore_regfile
    import seqcore_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int RIW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [NIB-1:0]  src_a_i,
    input  logic [NIB-1:0]  src_b_i,
    output logic [XLEN-1:0] val_a_o,
    output logic [XLEN-1:0] val_b_o,
    input  logic [NIB-1:0]  dst_e_i,
    input  logic [XLEN-1:0] val_e_i,
    input  logic [NIB-1:0]  dst_m_i,
    input  logic [XLEN-1:0] val_m_i,
    input  logic [NIB-1:0]  obs_sel_i,
    output logic [XLEN-1:0] obs_val_o
);

    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    function automatic logic [XLEN-1:0] read_port(input logic [NIB-1:0] id,
                                                 input logic [XLEN-1:0] file [NREGS]);
        if (32'(id) < NREGS) return file[id[RIW-1:0]];
        return '0;
    endfunction

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
            if (we_i && dst_m_i == NIB'(i))
                regs_d[i] = val_m_i;
            else if (we_i && dst_e_i == NIB'(i))
                regs_d[i] = val_e_i;
        end
        val_a_o   = read_port(src_a_i, regs_q);
        val_b_o   = read_port(src_b_i, regs_q);
        obs_val_o = read_port(obs_sel_i, regs_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
        end
    end

endmodule

// File: rtl/seqcore_mem.sv
module seqcore_mem
    import seqcore_pkg::*;
#(
    parameter int BYTES = 1024,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic                   clk,
    input  logic                   ld_en_i,
    input  logic [AW-1:0]          ld_addr_i,
    input  logic [7:0]             ld_data_i,
    input  logic                   wr_en_i,
    input  logic [XLEN-1:0]        wr_addr_i,
    input  logic [XLEN-1:0]        wr_data_i,
    input  logic [XLEN-1:0]        fetch_addr_i,
    output logic [FETCH_LEN*8-1:0] fetch_bytes_o,
    input  logic [XLEN-1:0]        rd_addr_i,
    output logic [XLEN-1:0]        rd_data_o,
    input  logic [AW-1:0]          obs_addr_i,
    output logic [XLEN-1:0]        obs_data_o
);

    localparam int WBYTES = XLEN / 8;

    logic [7:0] mem_q [BYTES];

    for (genvar k = 0; k < FETCH_LEN; k++) begin : g_fetch
        assign fetch_bytes_o[8*k +: 8] = mem_q[AW'(fetch_addr_i + XLEN'(k))];
    end

    for (genvar k = 0; k < WBYTES; k++) begin : g_word
        assign rd_data_o[8*k +: 8]  = mem_q[AW'(rd_addr_i + XLEN'(k))];
        assign obs_data_o[8*k +: 8] = mem_q[AW'(obs_addr_i + AW'(k))];
    end

    always_ff @(posedge clk) begin
        if (ld_en_i) begin
            mem_q[ld_addr_i] <= ld_data_i;
        end else if (wr_en_i) begin
            for (int k = 0; k < WBYTES; k++)
                mem_q[AW'(wr_addr_i + XLEN'(k))] <= wr_data_i[8*k +: 8];
        end
    end

endmodule

// File: rtl/seqcore_top.sv
module seqcore_top
    import seqcore_pkg::*;
#(
    parameter int              MEM_BYTES = 1024,
    parameter logic [XLEN-1:0] RESET_PC  = '0,
    localparam int             AW        = $clog2(MEM_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_addr,
    input  logic [7:0]      ld_data,
    input  logic [3:0]      obs_reg_sel,
    output logic [XLEN-1:0] obs_reg_val,
    input  logic [AW-1:0]   obs_mem_addr,
    output logic [XLEN-1:0] obs_mem_word,
    output logic [XLEN-1:0] pc,
    output logic [2:0]      flags,
    output logic            stopped,
    output logic            fault
);

    core_state_t state_q, state_d;

    logic [FETCH_LEN*8-1:0] ibytes;
    fetch_t                 fet;

    logic [NIB-1:0]  src_a, src_b, dst_e, dst_m, alu_fn;
    logic [XLEN-1:0] val_a, val_b, alu_a, alu_b, val_e, val_m;
    logic [XLEN-1:0] mem_addr, mem_wdata, new_pc;
    flags_t          alu_flags;
    logic            mem_wr, set_cc, take, live;

    logic [NIB-1:0]  dec_icode, dec_ifun;
    logic [XLEN-1:0] dec_valc;

    assign dec_icode = fet.icode;
    assign dec_ifun  = fet.ifun;
    assign dec_valc  = fet.valc;

    seqcore_mem #(.BYTES(MEM_BYTES)) u_mem (
        .clk           (clk),
        .ld_en_i       (ld_en),
        .ld_addr_i     (ld_addr),
        .ld_data_i     (ld_data),
        .wr_en_i       (mem_wr & live & rst_n),
        .wr_addr_i     (mem_addr),
        .wr_data_i     (mem_wdata),
        .fetch_addr_i  (state_q.pc),
        .fetch_bytes_o (ibytes),
        .rd_addr_i     (mem_addr),
        .rd_data_o     (val_m),
        .obs_addr_i    (obs_mem_addr),
        .obs_data_o    (obs_mem_word)
    );

    seqcore_fetch u_fetch (
        .pc_i    (state_q.pc),
        .bytes_i (ibytes),
        .fet_o   (fet)
    );

    seqcore_regfile #(.NREGS(8)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (live),
        .src_a_i   (src_a),
        .src_b_i   (src_b),
        .val_a_o   (val_a),
        .val_b_o   (val_b),
        .dst_e_i   (dst_e),
        .val_e_i   (val_e),
        .dst_m_i   (dst_m),
        .val_m_i   (val_m),
        .obs_sel_i (obs_reg_sel),
        .obs_val_o (obs_reg_val)
    );

    seqcore_alu u_alu (
        .a_i     (alu_a),
        .b_i     (alu_b),
        .fn_i    (alu_fn),
        .res_o   (val_e),
        .flags_o (alu_flags)
    );

    // Decode: register port selection per opcode
    always_comb begin
        case (fet.icode)
            OP_RRMOV, OP_RMMOV, OP_ALU, OP_PUSH: src_a = fet.ra;
            OP_POP, OP_RET:                      src_a = REG_SP;
            default:                             src_a = REG_NONE;
        endcase
        case (fet.icode)
            OP_ALU, OP_RMMOV, OP_MRMOV:          src_b = fet.rb;
            OP_PUSH, OP_POP, OP_CALL, OP_RET:    src_b = REG_SP;
            default:                             src_b = REG_NONE;
        endcase
        case (fet.icode)
            OP_RRMOV, OP_IRMOV, OP_ALU:          dst_e = fet.rb;
            OP_PUSH, OP_POP, OP_CALL, OP_RET:    dst_e = REG_SP;
            default:                             dst_e = REG_NONE;
        endcase
        case (fet.icode)
            OP_MRMOV, OP_POP:                    dst_m = fet.ra;
            default:                             dst_m = REG_NONE;
        endcase
    end

    // Execute: operand and function selection
    always_comb begin
        case (fet.icode)
            OP_RRMOV, OP_ALU:                    alu_a = val_a;
            OP_IRMOV, OP_RMMOV, OP_MRMOV:        alu_a = fet.valc;
            OP_CALL, OP_PUSH:                    alu_a = -XLEN'(4);
            OP_RET, OP_POP:                      alu_a = XLEN'(4);
            default:                             alu_a = '0;
        endcase
        case (fet.icode)
            OP_RRMOV, OP_IRMOV:                  alu_b = '0;
            default:                             alu_b = val_b;
        endcase
        alu_fn = (fet.icode == OP_ALU) ? fet.ifun : FN_ADD;
        set_cc = (fet.icode == OP_ALU);
        take   = branch_taken(fet.ifun, state_q.cc);
    end

    // Memory and next-PC selection
    always_comb begin
        case (fet.icode)
            OP_POP, OP_RET:                      mem_addr = val_a;
            default:                             mem_addr = val_e;
        endcase
        mem_wr    = fet.icode inside {OP_RMMOV, OP_PUSH, OP_CALL};
        mem_wdata = (fet.icode == OP_CALL) ? fet.valp : val_a;
        if (fet.icode == OP_CALL)
            new_pc = fet.valc;
        else if (fet.icode == OP_JUMP && take)
            new_pc = fet.valc;
        else if (fet.icode == OP_RET)
            new_pc = val_m;
        else
            new_pc = fet.valp;
        live = !state_q.stopped && fet.valid && (fet.icode != OP_HALT);
    end

    // Next architectural state
    always_comb begin
        state_d = state_q;
        if (!state_q.stopped) begin
            if (!fet.valid) begin
                state_d.stopped = 1'b1;
                state_d.fault   = 1'b1;
            end else if (fet.icode == OP_HALT) begin
                state_d.stopped = 1'b1;
            end else begin
                state_d.pc = new_pc;
                if (set_cc) state_d.cc = alu_flags;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pc      <= RESET_PC;
            state_q.cc      <= '{zf: 1'b1, sf: 1'b0, of: 1'b0};
            state_q.stopped <= 1'b0;
            state_q.fault   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc      = state_q.pc;
    assign flags   = state_q.cc;
    assign stopped = state_q.stopped;
    assign fault   = state_q.fault;

endmodule

// File: rtl/seqcore_checker.sv
module seqcore_checker
    import seqcore_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic [2:0]      flags,
    input logic            stopped,
    input logic            fault,
    input logic [NIB-1:0]  icode,
    input logic [NIB-1:0]  ifun,
    input logic [XLEN-1:0] valc,
    input logic [XLEN-1:0] valm
);

    a_r9_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> stopped && $stable(pc) && $stable(flags) && $stable(fault));

    a_r4_flags_only_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && icode != OP_ALU) |=> $stable(flags));

    a_r2_nop_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && icode == OP_NOP) |=> pc == $past(pc) + 32'd1);

    a_r8_call_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && icode == OP_CALL) |=> pc == $past(valc));

    a_r8_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && icode == OP_RET) |=> pc == $past(valm));

    a_r5_jmp_always: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && icode == OP_JUMP && ifun == 4'h0) |=> pc == $past(valc));

    a_r10_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && icode > OP_POP) |=> stopped && fault && pc == $past(pc));

    a_r9_halt_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && icode == OP_HALT) |=> stopped && !fault);

endmodule

bind seqcore_top seqcore_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc      (pc),
    .flags   (flags),
    .stopped (stopped),
    .fault   (fault),
    .icode   (dec_icode),
    .ifun    (dec_ifun),
    .valc    (dec_valc),
    .valm    (val_m)
);

// File: tb/seqcore_top_bench.sv
module seqcore_top_bench;

    localparam int MEMB = 1024;
    localparam int AW   = $clog2(MEMB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic [3:0]    obs_reg_sel = '0;
    logic [31:0]   obs_reg_val;
    logic [AW-1:0] obs_mem_addr = '0;
    logic [31:0]   obs_mem_word;
    logic [31:0]   pc;
    logic [2:0]    flags;
    logic          stopped, fault;

    always #5 clk = ~clk;

    seqcore_top #(.MEM_BYTES(MEMB)) u_seqcore_top (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .obs_reg_sel(obs_reg_sel), .obs_reg_val(obs_reg_val),
        .obs_mem_addr(obs_mem_addr), .obs_mem_word(obs_mem_word),
        .pc(pc), .flags(flags), .stopped(stopped), .fault(fault)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] prog [MEMB];
    int ptr;

    typedef struct packed {
        logic [3:0]  fn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic [2:0]  cc;
    } opvec_t;

    // a -> %eax (rA), b -> %ebx (rB); result = b op a; cc = {ZF,SF,OF}
    localparam opvec_t OPV [7] = '{
        '{4'h0, 32'd5,        32'd3,        32'd8,        3'b000},
        '{4'h1, 32'd3,        32'd3,        32'd0,        3'b100},
        '{4'h0, 32'd1,        32'h7fffffff, 32'h80000000, 3'b011},
        '{4'h1, 32'd1,        32'h80000000, 32'h7fffffff, 3'b001},
        '{4'h2, 32'h00000ff0, 32'h0000f0f0, 32'h000000f0, 3'b000},
        '{4'h3, 32'h0,        32'hffffffff, 32'hffffffff, 3'b010},
        '{4'h1, 32'd5,        32'd3,        32'hfffffffe, 3'b010}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < MEMB; i++) prog[i] = 8'h00;
        ptr = 0;
    endtask

    task automatic put(input logic [7:0] b);
        prog[ptr] = b;
        ptr++;
    endtask

    task automatic put_word(input logic [31:0] w);
        for (int k = 0; k < 4; k++) put(w[8*k +: 8]);
    endtask

    task automatic e_irmov(input logic [31:0] v, input logic [3:0] rb);
        put(8'h30); put({4'h8, rb}); put_word(v);
    endtask

    task automatic e_rr(input logic [3:0] code, input logic [3:0] fn,
                        input logic [3:0] ra, input logic [3:0] rb);
        put({code, fn}); put({ra, rb});
    endtask

    task automatic e_mem(input logic [3:0] code, input logic [3:0] ra,
                         input logic [3:0] rb, input logic [31:0] d);
        put({code, 4'h0}); put({ra, rb}); put_word(d);
    endtask

    task automatic e_dest(input logic [3:0] code, input logic [3:0] fn, input logic [31:0] d);
        put({code, fn}); put_word(d);
    endtask

    task automatic rd_reg(input logic [3:0] r, output logic [31:0] v);
        obs_reg_sel = r;
        #1 v = obs_reg_val;
    endtask

    task automatic rd_mem(input int a, output logic [31:0] v);
        obs_mem_addr = AW'(a);
        #1 v = obs_mem_word;
    endtask

    task automatic run_prog(input string tag);
        @(negedge clk) rst_n = 1'b0;
        for (int a = 0; a < MEMB; a++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(a); ld_data = prog[a];
        end
        @(negedge clk);
        ld_en = 1'b0;
        rst_n = 1'b1;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (stopped) break;
        end
        chk(tag, "core reached stop", {31'd0, stopped}, 32'd1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        lt, eq, tk;
        logic [31:0] ja, jb;

        // R11: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "pc", pc, 32'd0);
        chk("R11", "flags", {29'd0, flags}, 32'h4);
        chk("R11", "stopped", {31'd0, stopped}, 32'd0);
        chk("R11", "fault", {31'd0, fault}, 32'd0);
        for (int r = 0; r < 8; r++) begin
            rd_reg(4'(r), v);
            chk("R11", "register zero", v, 32'd0);
        end

        // R3 R4 R2: OPl vector table
        for (int i = 0; i < 7; i++) begin
            clear_prog();
            e_irmov(OPV[i].a, 4'h0);
            e_irmov(OPV[i].b, 4'h3);
            e_rr(4'h6, OPV[i].fn, 4'h0, 4'h3);
            put(8'h10);
            run_prog("R3");
            rd_reg(4'h3, v);
            chk("R3", "alu result in rB", v, OPV[i].res);
            chk("R4", "flags after alu", {29'd0, flags}, {29'd0, OPV[i].cc});
            chk("R2", "halt address 6+6+2", pc, 32'd14);
            chk("R9", "halt no fault", {31'd0, fault}, 32'd0);
        end

        // R5: every condition against equal, lower, higher
        for (int rel = 0; rel < 3; rel++) begin
            for (int fn = 0; fn < 7; fn++) begin
                ja = (rel == 0) ? 32'd5 : (rel == 1) ? 32'd9 : 32'd2;
                jb = (rel == 0) ? 32'd5 : (rel == 1) ? 32'd2 : 32'd9;
                eq = (rel == 0);
                lt = (rel == 1);
                case (fn)
                    0: tk = 1'b1;
                    1: tk = lt | eq;
                    2: tk = lt;
                    3: tk = eq;
                    4: tk = !eq;
                    5: tk = !lt;
                    default: tk = !lt && !eq;
                endcase
                clear_prog();
                e_irmov(ja, 4'h0);             // 0
                e_irmov(jb, 4'h3);             // 6
                e_rr(4'h6, 4'h1, 4'h0, 4'h3);  // 12: ebx - eax
                e_dest(4'h7, 4'(fn), 32'd26);  // 14
                e_irmov(32'd1, 4'h1);          // 19
                put(8'h10);                    // 25
                e_irmov(32'd2, 4'h1);          // 26
                put(8'h10);                    // 32
                run_prog("R5");
                rd_reg(4'h1, v);
                chk("R5", "branch path marker", v, tk ? 32'd2 : 32'd1);
                chk("R5", "halt address", pc, tk ? 32'd32 : 32'd25);
            end
        end

        // R6 R1: moves through memory, byte order
        clear_prog();
        e_irmov(32'h12345678, 4'h1);
        e_irmov(32'h00000200, 4'h2);
        e_mem(4'h4, 4'h1, 4'h2, 32'd8);
        e_mem(4'h5, 4'h6, 4'h2, 32'd8);
        e_rr(4'h2, 4'h0, 4'h6, 4'h7);
        put(8'h10);
        run_prog("R6");
        rd_mem(32'h208, v);
        chk("R6", "stored word", v, 32'h12345678);
        rd_mem(32'h209, v);
        chk("R1", "little-endian byte order", v, 32'h00123456);
        rd_reg(4'h6, v);
        chk("R6", "loaded word in esi", v, 32'h12345678);
        rd_reg(4'h7, v);
        chk("R6", "register copy to edi", v, 32'h12345678);
        chk("R2", "halt address after moves", pc, 32'd26);

        // R7: push then halt
        clear_prog();
        e_irmov(32'h100, 4'h4);
        e_irmov(32'hAABBCCDD, 4'h0);
        e_rr(4'hA, 4'h0, 4'h0, 4'h8);
        put(8'h10);
        run_prog("R7");
        rd_reg(4'h4, v);
        chk("R7", "esp after push", v, 32'hfc);
        rd_mem(32'hfc, v);
        chk("R7", "pushed word", v, 32'hAABBCCDD);

        // R7: push then pop
        clear_prog();
        e_irmov(32'h100, 4'h4);
        e_irmov(32'hAABBCCDD, 4'h0);
        e_rr(4'hA, 4'h0, 4'h0, 4'h8);
        e_rr(4'hB, 4'h0, 4'h3, 4'h8);
        put(8'h10);
        run_prog("R7");
        rd_reg(4'h4, v);
        chk("R7", "esp after pop", v, 32'h100);
        rd_reg(4'h3, v);
        chk("R7", "popped value", v, 32'hAABBCCDD);

        // R7: popl %esp keeps the loaded value
        clear_prog();
        e_irmov(32'h100, 4'h4);
        e_irmov(32'h55, 4'h0);
        e_rr(4'hA, 4'h0, 4'h0, 4'h8);
        e_rr(4'hB, 4'h0, 4'h4, 4'h8);
        put(8'h10);
        run_prog("R7");
        rd_reg(4'h4, v);
        chk("R7", "popl esp priority", v, 32'h55);

        // R8: call and ret
        clear_prog();
        e_irmov(32'h100, 4'h4);   // 0
        e_dest(4'h8, 4'h0, 32'h20); // 6
        e_irmov(32'd7, 4'h0);     // 11
        put(8'h10);               // 17
        ptr = 32'h20;
        e_irmov(32'd9, 4'h1);
        put(8'h90);
        run_prog("R8");
        rd_reg(4'h0, v);
        chk("R8", "code after return ran", v, 32'd7);
        rd_reg(4'h1, v);
        chk("R8", "subroutine ran", v, 32'd9);
        rd_reg(4'h4, v);
        chk("R8", "esp restored", v, 32'h100);
        rd_mem(32'hfc, v);
        chk("R8", "return address on stack", v, 32'd11);
        chk("R8", "halt address", pc, 32'd17);

        // R10: bad opcode
        clear_prog();
        e_irmov(32'd3, 4'h0);
        put(8'hC0);
        e_irmov(32'd4, 4'h0);
        put(8'h10);
        run_prog("R10");
        chk("R10", "fault flag", {31'd0, fault}, 32'd1);
        chk("R10", "pc at bad opcode", pc, 32'd6);
        repeat (5) @(negedge clk);
        chk("R10", "pc frozen", pc, 32'd6);
        rd_reg(4'h0, v);
        chk("R10", "later code not run", v, 32'd3);

        // R9 R12: halt
        clear_prog();
        e_irmov(32'd1, 4'h0);
        put(8'h00);
        put(8'h10);
        e_irmov(32'd2, 4'h0);
        run_prog("R9");
        chk("R9", "fault low", {31'd0, fault}, 32'd0);
        chk("R9", "pc at halt", pc, 32'd7);
        repeat (5) @(negedge clk);
        chk("R9", "pc frozen", pc, 32'd7);
        chk("R9", "flags unchanged", {29'd0, flags}, 32'h4);
        chk("R9", "stopped held", {31'd0, stopped}, 32'd1);
        rd_reg(4'h0, v);
        chk("R9", "code after halt not run", v, 32'd1);
        rd_mem(0, v);
        chk("R12", "loaded bytes readable", v, 32'h00018030);

        summary();
        $finish;
    end

endmodule